// File: doc/BRIEF.md
# Single-Bit Manipulation and Test Unit

This unit performs one-bit operations on an 8-bit value taken from a register or an I/O location. A single 4-bit descriptor names both the bit position (its low three bits) and the polarity (its top bit). An operation select picks one of four actions:

- forcing the chosen bit high or low;
- copying the chosen bit into the T status flag;
- writing T into the chosen bit;
- testing the chosen bit for a later skip.

The value and flag paths are combinational. They return the new value, the new T flag, and which of the two writes should take effect.

A test-and-skip instruction takes two cycles. In the first cycle, a capture strobe stores whether the chosen bit matches the descriptor polarity in a holding flag. In the second cycle, the skip request reads that stored flag instead of the live operand. This keeps the bit extraction and the skip decision in separate cycles. The unit also forms the I/O address for the bit-on-I/O forms by adding a fixed base to a short field from the instruction.

Top module: `bitop_unit`

## Requirements
- R1: With op_sel = 1 (force bit), result equals operand with bit bit_desc[2:0] set when bit_desc[3] = 1 or cleared when bit_desc[3] = 0. All other bits pass through. val_we = 1 and t_we = 0.
- R2: With op_sel = 2 (bit to flag), t_out equals operand[bit_desc[2:0]] whatever bit_desc[3] holds. result equals operand, t_we = 1 and val_we = 0.
- R3: With op_sel = 3 (flag to bit), result equals operand with bit bit_desc[2:0] replaced by t_in and all other bits unchanged. val_we = 1 and t_we = 0.
- R4: For op_sel = 0 (idle), 4 (test) and the unused codes 5 to 7, result equals operand, t_out equals t_in, and val_we = t_we = 0.
- R5: io_addr equals io_field plus 0x20, for every value of io_field.
- R6: On a rising clock edge with capture_en = 1, test_bit loads 1 if operand[bit_desc[2:0]] equals bit_desc[3], else 0. With capture_en = 0, test_bit keeps its value regardless of the other inputs.
- R7: skip_out is 1 exactly when skip_eval = 1 and test_bit = 1. It uses the stored flag, not the present operand.
- R8: While rst_n is low, test_bit is 0 and so skip_out is 0. After rst_n rises, captures take effect from the third rising edge on, because the reset release passes through two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_sel | input | 3 | Operation code: 0 idle, 1 force bit, 2 bit to flag, 3 flag to bit, 4 test |
| operand | input | 8 | Value being operated on |
| bit_desc | input | 4 | [2:0] bit position, [3] polarity |
| t_in | input | 1 | Current T status flag |
| io_field | input | 5 | I/O field from the instruction |
| capture_en | input | 1 | Strobe that loads the holding flag |
| skip_eval | input | 1 | Second-cycle skip request |
| result | output | 8 | Modified value |
| val_we | output | 1 | Value write should take effect |
| t_out | output | 1 | New T flag |
| t_we | output | 1 | Status flag write should take effect |
| io_addr | output | 6 | I/O address, io_field + 0x20 |
| test_bit | output | 1 | Holding flag |
| skip_out | output | 1 | Skip decision |

## Verification
The bench sweeps every bit position with both polarities over several operand patterns. An off-by-one mask would change the wrong bit, and inverted polarity handling would set bits instead of clearing them. It checks that the flag copy ignores the polarity bit and that the flag insert follows t_in rather than the polarity bit. Mixing up those two fields would write the wrong value.

Between capture and evaluation, the bench changes the operand on purpose. A skip computed from the live operand, or a holding flag that reloads without the strobe, would then give the wrong decision. An asynchronous reset in the middle of a run, with the stored flag set, shows whether that flag is cleared at once.

// File: rtl/bitop_pkg.sv
`timescale 1ns/1ps
package bitop_pkg;
  typedef enum logic [2:0] {
    BOP_IDLE  = 3'd0,
    BOP_FORCE = 3'd1,
    BOP_TO_T  = 3'd2,
    BOP_FROM_T = 3'd3,
    BOP_TEST  = 3'd4
  } bop_e;

  typedef struct packed {
    logic val_we;
    logic t_we;
  } bop_we_t;
endpackage

// File: rtl/bitop_rst_sync.sv
`timescale 1ns/1ps
module bitop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_int_n = sync_q[STAGES-1];
endmodule

// File: rtl/bitop_mask.sv
`timescale 1ns/1ps
module bitop_mask #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] mask
);
  for (genvar k = 0; k < DATA_W; k++) begin : g_dec
    assign mask[k] = (idx == IDX_W'(k));
  end
endmodule

// File: rtl/bitop_datapath.sv
`timescale 1ns/1ps
module bitop_datapath
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] mask,
  input  logic              polarity,
  input  logic              t_in,
  output logic [DATA_W-1:0] result,
  output logic              t_out,
  output bop_we_t           we,
  output logic              sel_bit
);
  bop_e op;
  logic [DATA_W-1:0] set_val;
  logic [DATA_W-1:0] clr_val;

  always_comb begin
    op      = bop_e'(op_sel);
    sel_bit = |(operand & mask);
    set_val = operand | mask;
    clr_val = operand & ~mask;
    result  = operand;
    t_out   = t_in;
    we      = '0;
    case (op)
      BOP_FORCE: begin
        result    = polarity ? set_val : clr_val;
        we.val_we = 1'b1;
      end
      BOP_TO_T: begin
        t_out   = sel_bit;
        we.t_we = 1'b1;
      end
      BOP_FROM_T: begin
        result    = t_in ? set_val : clr_val;
        we.val_we = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitop_hold.sv
`timescale 1ns/1ps
module bitop_hold (
  input  logic clk,
  input  logic rst_int_n,
  input  logic capture_en,
  input  logic sel_bit,
  input  logic polarity,
  input  logic skip_eval,
  output logic test_bit,
  output logic skip_out
);
  logic hold_q;
  logic hold_d;

  always_comb begin
    hold_d = hold_q;
    if (capture_en) hold_d = (sel_bit == polarity);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) hold_q <= 1'b0;
    else            hold_q <= hold_d;
  end

  assign test_bit = hold_q;
  assign skip_out = skip_eval & hold_q;
endmodule

// File: rtl/bitop_unit.sv
`timescale 1ns/1ps
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int IO_FIELD_W = 5,
  parameter int IO_BASE    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int DESC_W = IDX_W + 1,
  localparam int ADDR_W = $clog2(IO_BASE + (1 << IO_FIELD_W))
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            op_sel,
  input  logic [DATA_W-1:0]     operand,
  input  logic [DESC_W-1:0]     bit_desc,
  input  logic                  t_in,
  input  logic [IO_FIELD_W-1:0] io_field,
  input  logic                  capture_en,
  input  logic                  skip_eval,
  output logic [DATA_W-1:0]     result,
  output logic                  val_we,
  output logic                  t_out,
  output logic                  t_we,
  output logic [ADDR_W-1:0]     io_addr,
  output logic                  test_bit,
  output logic                  skip_out
);
  logic              rst_int_n;
  logic [DATA_W-1:0] mask;
  logic              polarity;
  logic              sel_bit;
  bop_we_t           we;

  assign polarity = bit_desc[DESC_W-1];

  bitop_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  bitop_mask #(.DATA_W(DATA_W)) u_mask (
    .idx(bit_desc[IDX_W-1:0]), .mask(mask)
  );

  bitop_datapath #(.DATA_W(DATA_W)) u_dp (
    .op_sel(op_sel), .operand(operand), .mask(mask), .polarity(polarity),
    .t_in(t_in), .result(result), .t_out(t_out), .we(we), .sel_bit(sel_bit)
  );

  bitop_hold u_hold (
    .clk(clk), .rst_int_n(rst_int_n), .capture_en(capture_en),
    .sel_bit(sel_bit), .polarity(polarity), .skip_eval(skip_eval),
    .test_bit(test_bit), .skip_out(skip_out)
  );

  assign val_we  = we.val_we;
  assign t_we    = we.t_we;
  assign io_addr = ADDR_W'(io_field) + ADDR_W'(IO_BASE);
endmodule

// File: rtl/bitop_unit_chk.sv
`timescale 1ns/1ps
module bitop_unit_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int IO_BASE = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_sel,
  input logic [DATA_W-1:0] operand,
  input logic              t_in,
  input logic              capture_en,
  input logic [DATA_W-1:0] result,
  input logic              val_we,
  input logic              t_out,
  input logic              t_we,
  input logic [ADDR_W-1:0] io_addr,
  input logic              test_bit,
  input logic              skip_out
);
  assert_force_one_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd1) |-> (val_we && !t_we && $countones(result ^ operand) <= 1));

  assert_to_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd2) |-> (t_we && !val_we && result == operand));

  assert_from_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd3) |-> (val_we && !t_we && $countones(result ^ operand) <= 1));

  assert_passive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd0 || op_sel >= 3'd4) |-> (!val_we && !t_we && result == operand && t_out == t_in));

  assert_io_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    io_addr >= ADDR_W'(IO_BASE));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_en |=> $stable(test_bit));

  assert_skip_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_out |-> test_bit);

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |-> (!test_bit && !skip_out));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand), .t_in(t_in),
  .capture_en(capture_en), .result(result), .val_we(val_we), .t_out(t_out),
  .t_we(t_we), .io_addr(io_addr), .test_bit(test_bit), .skip_out(skip_out)
);

// File: tb/test_bitop_unit.sv
`timescale 1ns/1ps
module test_bitop_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_sel;
  logic [7:0] operand;
  logic [3:0] bit_desc;
  logic       t_in;
  logic [4:0] io_field;
  logic       capture_en;
  logic       skip_eval;
  logic [7:0] result;
  logic       val_we, t_out, t_we, test_bit, skip_out;
  logic [5:0] io_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit m_held = 0;

  always #2 clk = ~clk;

  bitop_unit i_bitop_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand),
    .bit_desc(bit_desc), .t_in(t_in), .io_field(io_field),
    .capture_en(capture_en), .skip_eval(skip_eval), .result(result),
    .val_we(val_we), .t_out(t_out), .t_we(t_we), .io_addr(io_addr),
    .test_bit(test_bit), .skip_out(skip_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input [2:0] op, input [7:0] opd, input [3:0] desc,
                      input t, input [4:0] f, input cap, input sk);
    logic [7:0] e_res;
    logic e_t, e_vwe, e_twe;
    string tag;
    op_sel = op; operand = opd; bit_desc = desc; t_in = t;
    io_field = f; capture_en = cap; skip_eval = sk;
    e_res = opd; e_t = t; e_vwe = 0; e_twe = 0; tag = "R4";
    case (op)
      3'd1: begin e_res[desc[2:0]] = desc[3]; e_vwe = 1; tag = "R1"; end
      3'd2: begin e_t = opd[desc[2:0]]; e_twe = 1; tag = "R2"; end
      3'd3: begin e_res[desc[2:0]] = t; e_vwe = 1; tag = "R3"; end
      default: ;
    endcase
    @(negedge clk);
    chk({tag, " result"}, result, e_res);
    chk({tag, " t_out"}, t_out, e_t);
    chk({tag, " val_we"}, val_we, e_vwe);
    chk({tag, " t_we"}, t_we, e_twe);
    chk("R5 io_addr", io_addr, f + 32);
    chk("R6 test_bit", test_bit, m_held);
    chk("R7 skip_out", skip_out, sk & m_held);
    @(posedge clk);
    if (cap) m_held = (opd[desc[2:0]] == desc[3]);
    #1;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81};
    rst_n = 0; op_sel = 0; operand = 8'hFF; bit_desc = 4'hF; t_in = 1;
    io_field = 0; capture_en = 1; skip_eval = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset test_bit", test_bit, 0);
    chk("R8 reset skip_out", skip_out, 0);
    @(posedge clk); #1;
    rst_n = 1; capture_en = 0;
    repeat (4) step(3'd0, 8'h3C, 4'h2, 0, 5'd0, 0, 1);

    // R1 force bit, R2 copy to flag, R3 insert flag over all positions
    foreach (pats[p]) begin
      for (int d = 0; d < 16; d++) begin
        step(3'd1, pats[p], 4'(d), d[0], 5'(d), 0, 0);
        step(3'd2, pats[p], 4'(d), ~pats[p][d[2:0]], 5'(d + 16), 0, 0);
        step(3'd3, pats[p], 4'(d), 1'b1, 5'(p), 0, 0);
        step(3'd3, pats[p], 4'(d), 1'b0, 5'(p), 0, 0);
      end
    end
    // R4 passive codes
    for (int o = 0; o < 8; o++) begin
      if (o >= 1 && o <= 3) continue;
      step(3'(o), 8'h96, 4'hB, 1'b1, 5'd31, 0, 0);
      step(3'(o), 8'h69, 4'h4, 1'b0, 5'd1, 0, 0);
    end
    // R5 every io field
    for (int f = 0; f < 32; f++) step(3'd0, 8'(f), 4'h0, 0, 5'(f), 0, 0);

    // R6 / R7 capture then evaluate with changed operand
    step(3'd4, 8'h08, 4'hB, 0, 5'd0, 1, 0);  // bit3=1, pol 1 -> match
    step(3'd4, 8'h00, 4'hB, 0, 5'd0, 0, 1);  // operand changed, skip uses stored
    step(3'd1, 8'h00, 4'h3, 0, 5'd0, 0, 1);
    step(3'd4, 8'h08, 4'h3, 0, 5'd0, 1, 0);  // pol 0, bit 1 -> no match
    step(3'd4, 8'h00, 4'h3, 0, 5'd0, 0, 1);
    step(3'd4, 8'h00, 4'h3, 0, 5'd0, 1, 1);  // bit 0 matches pol 0
    step(3'd4, 8'hFF, 4'h3, 0, 5'd0, 0, 1);
    step(3'd4, 8'hFF, 4'h3, 0, 5'd0, 0, 0);

    // R8 asynchronous reset mid-run with flag held
    rst_n = 0;
    #1;
    chk("R8 async clear test_bit", test_bit, 0);
    m_held = 0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1;
    repeat (3) step(3'd0, 8'h55, 4'h8, 0, 5'd2, 0, 1);
    step(3'd4, 8'h01, 4'h8, 0, 5'd2, 1, 1);
    step(3'd0, 8'h00, 4'h8, 0, 5'd2, 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule